// File: doc/BRIEF.md
# Fuse-Array Boot Sequencer

The block runs once after every reset and decides how the chip comes up from an on-die one-time-programmable (OTP) fuse array. It reads a marker word and a configuration word from the top of the array. A blank marker hands the chip to an external serial downloader. A programmed part with security on compares a key region of the array against a key supplied at an input. A programmed part with security off goes straight to the image. When the boot succeeds, the image is copied word by word into shared RAM and a single execute strobe releases the processor. A failed key comparison parks the block in a locked fault state.

The block also times fuse programming pulses. Each accepted programming request drives a blow enable for a fixed number of clock cycles. That count is derived from a pulse width in microseconds, kept between 10 and 100, and the clock frequency. A lock bit in the configuration word stops all further programming.

The OTP read port has one cycle of latency: data for an address presented in cycle t is on `otp_rd_data` in cycle t+1. A blown fuse reads as 1, so a blank word reads as all zeros.

Top module: `boot_sequencer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `exec_strobe`, `dl_enable`, `boot_fault`, `ram_wr_en` and `fuse_blow` are all 0.
- R2: The marker is OTP word DEPTH-1. If it reads all zeros or all ones, the part counts as blank. `dl_enable` then stays at 1 until reset, no RAM write happens, `exec_strobe` never pulses and `boot_fault` stays 0.
- R3: The configuration is OTP word DEPTH-2. Bit 0 is secure, bit 1 is programming lock, and bits [8 +: OTP_AW] are the image length N. With a valid marker and bit 0 clear, OTP words 0..N-1 are written to RAM addresses 0..N-1 in ascending order, one per consecutive cycle. No key word is compared.
- R4: An N larger than IMG_MAX = DEPTH-2-KEY_WORDS copies IMG_MAX words. An N of 0 copies nothing.
- R5: On a successful boot `exec_strobe` is high for exactly one cycle. That cycle comes immediately after the cycle of the last RAM write, or after the decision when N is 0. The strobe never occurs again before reset.
- R6: With a valid marker and bit 0 set, OTP word DEPTH-2-KEY_WORDS+i is compared with `sec_key[32*i +: 32]` for every i before any RAM write. If all are equal, the copy and strobe of R3 to R5 follow.
- R7: If any key word differs, `boot_fault` goes to 1 and stays there until reset. No RAM write follows, `exec_strobe` does not pulse, and `dl_enable` stays 0.
- R8: In the downloader state, or after the execute strobe, with the lock bit clear, a `prog_req` cycle starts `fuse_blow` on the next cycle. `fuse_blow` stays high for BLOW cycles, and `fuse_blow_addr` holds the requested `prog_bit_addr` throughout.
- R9: BLOW = clamp(BLOW_US, 10, 100) * CLK_MHZ.
- R10: `prog_req` is ignored when the lock bit is set, including on a blank marker. It is also ignored during the boot decision, key check and copy, in the fault state, and while a pulse is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| otp_rd_en | output | 1 | OTP read request |
| otp_rd_addr | output | OTP_AW | OTP word address |
| otp_rd_data | input | 32 | OTP read data, one cycle after request |
| ram_wr_en | output | 1 | Shared RAM write enable |
| ram_wr_addr | output | RAM_AW | Shared RAM word address |
| ram_wr_data | output | 32 | Shared RAM write data |
| sec_key | input | 32*KEY_WORDS | Reference key, word i in bits [32*i +: 32] |
| prog_req | input | 1 | Fuse programming request, one cycle |
| prog_bit_addr | input | OTP_AW+5 | Fuse bit to program |
| fuse_blow | output | 1 | Fuse programming drive enable |
| fuse_blow_addr | output | OTP_AW+5 | Fuse bit being programmed |
| dl_enable | output | 1 | Hands the chip to the external downloader |
| exec_strobe | output | 1 | One-cycle processor release |
| boot_fault | output | 1 | Locked key-mismatch fault |

## Verification
The hardest outcomes to reach from the ports are a key mismatch on the last key word after the earlier words matched, and a set lock bit on a part whose marker is still blank. A pipelined compare could lose the last word, and a blank-path shortcut could skip the lock. The bench reaches both by loading the OTP model with crafted marker, configuration and key words before each reset. It then issues programming requests in every terminal state, including requests held high through the boot decision and requests repeated while a pulse is running. Image length is swept over every value of its field in both open and secure mode, so the clamp and the zero-length boot are both covered.

// File: rtl/boot_pkg.sv
package boot_pkg;

    localparam int unsigned WORD_W       = 32;
    localparam int unsigned FUSE_US_MIN  = 10;
    localparam int unsigned FUSE_US_MAX  = 100;
    localparam int unsigned CFG_SEC_BIT  = 0;
    localparam int unsigned CFG_LOCK_BIT = 1;
    localparam int unsigned CFG_LEN_LSB  = 8;

    typedef logic [WORD_W-1:0] word_t;

    // Kind of OTP read in flight, returned with the data
    typedef enum logic [1:0] {
        TAG_MARK,
        TAG_CFG,
        TAG_KEY,
        TAG_IMG
    } fetch_tag_e;

    typedef enum logic [3:0] {
        ST_MARK,
        ST_CFG,
        ST_DECIDE,
        ST_KEY,
        ST_KEY_W,
        ST_COPY,
        ST_COPY_W,
        ST_EXEC,
        ST_RUN,
        ST_DL,
        ST_FAULT
    } boot_state_e;

    typedef struct packed {
        logic secure;
        logic locked;
    } boot_flags_t;

    // Blank (never blown) and fully blown markers both count as unprogrammed
    function automatic logic marker_programmed(word_t w);
        return (w != '0) && (w != '1);
    endfunction

    function automatic int unsigned blow_cycles(int unsigned us, int unsigned mhz);
        int unsigned c;
        c = us;
        if (c < FUSE_US_MIN) c = FUSE_US_MIN;
        if (c > FUSE_US_MAX) c = FUSE_US_MAX;
        return c * mhz;
    endfunction

endpackage

// File: rtl/boot_otp_fetch.sv
module boot_otp_fetch
    import boot_pkg::*;
#(
    parameter int unsigned OTP_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [OTP_AW-1:0] req_addr,
    input  fetch_tag_e        req_tag,
    output logic              otp_rd_en,
    output logic [OTP_AW-1:0] otp_rd_addr,
    input  word_t             otp_rd_data,
    output logic              rsp_valid,
    output logic [OTP_AW-1:0] rsp_addr,
    output fetch_tag_e        rsp_tag,
    output word_t             rsp_data
);

    assign otp_rd_en   = req_valid;
    assign otp_rd_addr = req_addr;
    assign rsp_data    = otp_rd_data;

    // The array answers one cycle later; carry address and kind alongside
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_tag   <= TAG_MARK;
        end else begin
            rsp_valid <= req_valid;
            rsp_addr  <= req_addr;
            rsp_tag   <= req_tag;
        end
    end

endmodule

// File: rtl/boot_ctrl.sv
module boot_ctrl
    import boot_pkg::*;
#(
    parameter int unsigned OTP_AW    = 6,
    parameter int unsigned KEY_WORDS = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [KEY_WORDS*WORD_W-1:0] sec_key,
    output logic                        req_valid,
    output logic [OTP_AW-1:0]           req_addr,
    output fetch_tag_e                  req_tag,
    input  logic                        rsp_valid,
    input  logic [OTP_AW-1:0]           rsp_addr,
    input  fetch_tag_e                  rsp_tag,
    input  word_t                       rsp_data,
    output logic                        img_wr_en,
    output logic [OTP_AW-1:0]           img_wr_addr,
    output word_t                       img_wr_data,
    output logic                        exec_strobe,
    output logic                        dl_enable,
    output logic                        boot_fault,
    output logic                        prog_allowed
);

    localparam int unsigned DEPTH   = 1 << OTP_AW;
    localparam int unsigned KEY_LO  = DEPTH - 2 - KEY_WORDS;
    localparam logic [OTP_AW-1:0] MARK_A    = OTP_AW'(DEPTH - 1);
    localparam logic [OTP_AW-1:0] CFG_A     = OTP_AW'(DEPTH - 2);
    localparam logic [OTP_AW-1:0] KEY_A     = OTP_AW'(KEY_LO);
    localparam logic [OTP_AW-1:0] IMG_MAX_A = OTP_AW'(KEY_LO);
    localparam logic [OTP_AW-1:0] KEY_LAST  = OTP_AW'(KEY_WORDS - 1);

    boot_state_e       state_q, state_d;
    logic [OTP_AW-1:0] idx_q, idx_d;
    logic [OTP_AW-1:0] len_q;
    logic              marker_ok_q;
    boot_flags_t       flags_q;
    logic              mismatch_q;

    // Reference key split into words
    word_t key_words [KEY_WORDS];
    for (genvar g = 0; g < KEY_WORDS; g++) begin : g_key
        assign key_words[g] = sec_key[g*WORD_W +: WORD_W];
    end

    word_t key_sel;
    always_comb begin
        key_sel = '0;
        for (int i = 0; i < KEY_WORDS; i++) begin
            if (rsp_addr == KEY_A + OTP_AW'(i)) key_sel = key_words[i];
        end
    end

    logic key_bad;
    assign key_bad = rsp_valid && (rsp_tag == TAG_KEY) && (rsp_data != key_sel);

    // Configuration decode, valid while the configuration word is returning
    boot_flags_t       cfg_flags;
    logic [OTP_AW-1:0] cfg_len_raw, cfg_len;
    always_comb begin
        cfg_flags.secure = rsp_data[CFG_SEC_BIT];
        cfg_flags.locked = rsp_data[CFG_LOCK_BIT];
        cfg_len_raw      = rsp_data[CFG_LEN_LSB +: OTP_AW];
        cfg_len          = (cfg_len_raw > IMG_MAX_A) ? IMG_MAX_A : cfg_len_raw;
    end

    always_comb begin
        state_d   = state_q;
        idx_d     = idx_q;
        req_valid = 1'b0;
        req_addr  = '0;
        req_tag   = TAG_IMG;
        unique case (state_q)
            ST_MARK: begin
                req_valid = 1'b1;
                req_addr  = MARK_A;
                req_tag   = TAG_MARK;
                state_d   = ST_CFG;
            end
            ST_CFG: begin
                req_valid = 1'b1;
                req_addr  = CFG_A;
                req_tag   = TAG_CFG;
                state_d   = ST_DECIDE;
            end
            ST_DECIDE: begin
                idx_d = '0;
                if (!marker_ok_q)            state_d = ST_DL;
                else if (cfg_flags.secure)   state_d = ST_KEY;
                else if (cfg_len == '0)      state_d = ST_EXEC;
                else                         state_d = ST_COPY;
            end
            ST_KEY: begin
                req_valid = 1'b1;
                req_addr  = KEY_A + idx_q;
                req_tag   = TAG_KEY;
                idx_d     = idx_q + OTP_AW'(1);
                if (idx_q == KEY_LAST) begin
                    idx_d   = '0;
                    state_d = ST_KEY_W;
                end
            end
            ST_KEY_W: begin
                if (mismatch_q || key_bad) state_d = ST_FAULT;
                else if (len_q == '0)      state_d = ST_EXEC;
                else                       state_d = ST_COPY;
            end
            ST_COPY: begin
                req_valid = 1'b1;
                req_addr  = idx_q;
                req_tag   = TAG_IMG;
                idx_d     = idx_q + OTP_AW'(1);
                if (idx_q == len_q - OTP_AW'(1)) state_d = ST_COPY_W;
            end
            ST_COPY_W: state_d = ST_EXEC;
            ST_EXEC:   state_d = ST_RUN;
            ST_RUN:    state_d = ST_RUN;
            ST_DL:     state_d = ST_DL;
            ST_FAULT:  state_d = ST_FAULT;
            default:   state_d = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_MARK;
            idx_q       <= '0;
            len_q       <= '0;
            marker_ok_q <= 1'b0;
            flags_q     <= '0;
            mismatch_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (rsp_valid && rsp_tag == TAG_MARK) marker_ok_q <= marker_programmed(rsp_data);
            if (rsp_valid && rsp_tag == TAG_CFG) begin
                flags_q <= cfg_flags;
                len_q   <= cfg_len;
            end
            if (state_q == ST_DECIDE) mismatch_q <= 1'b0;
            else if (key_bad)         mismatch_q <= 1'b1;
        end
    end

    assign img_wr_en    = rsp_valid && (rsp_tag == TAG_IMG);
    assign img_wr_addr  = rsp_addr;
    assign img_wr_data  = rsp_data;
    assign exec_strobe  = (state_q == ST_EXEC);
    assign dl_enable    = (state_q == ST_DL);
    assign boot_fault   = (state_q == ST_FAULT);
    assign prog_allowed = ((state_q == ST_DL) || (state_q == ST_RUN)) && !flags_q.locked;

endmodule

// File: rtl/boot_fuse_pulse.sv
module boot_fuse_pulse #(
    parameter int unsigned BIT_AW = 11,
    parameter int unsigned CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              allowed,
    input  logic              prog_req,
    input  logic [BIT_AW-1:0] prog_bit_addr,
    output logic              fuse_blow,
    output logic [BIT_AW-1:0] fuse_blow_addr
);

    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q         <= 1'b0;
            cnt_q          <= '0;
            fuse_blow_addr <= '0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) busy_q <= 1'b0;
        end else if (prog_req && allowed) begin
            busy_q         <= 1'b1;
            cnt_q          <= CW'(CYCLES);
            fuse_blow_addr <= prog_bit_addr;
        end
    end

    assign fuse_blow = busy_q;

endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
    import boot_pkg::*;
#(
    parameter int unsigned OTP_AW    = 6,
    parameter int unsigned RAM_AW    = 8,
    parameter int unsigned KEY_WORDS = 2,
    parameter int unsigned CLK_MHZ   = 100,
    parameter int unsigned BLOW_US   = 20
) (
    input  logic                        clk,
    input  logic                        rst,
    output logic                        otp_rd_en,
    output logic [OTP_AW-1:0]           otp_rd_addr,
    input  logic [31:0]                 otp_rd_data,
    output logic                        ram_wr_en,
    output logic [RAM_AW-1:0]           ram_wr_addr,
    output logic [31:0]                 ram_wr_data,
    input  logic [KEY_WORDS*32-1:0]     sec_key,
    input  logic                        prog_req,
    input  logic [OTP_AW+4:0]           prog_bit_addr,
    output logic                        fuse_blow,
    output logic [OTP_AW+4:0]           fuse_blow_addr,
    output logic                        dl_enable,
    output logic                        exec_strobe,
    output logic                        boot_fault
);

    localparam int unsigned BLOW_N = blow_cycles(BLOW_US, CLK_MHZ);
    localparam int unsigned BIT_AW = OTP_AW + 5;

    logic              req_valid;
    logic [OTP_AW-1:0] req_addr;
    fetch_tag_e        req_tag;
    logic              rsp_valid;
    logic [OTP_AW-1:0] rsp_addr;
    fetch_tag_e        rsp_tag;
    word_t             rsp_data;
    logic              img_wr_en;
    logic [OTP_AW-1:0] img_wr_addr;
    word_t             img_wr_data;
    logic              prog_allowed;

    boot_otp_fetch #(.OTP_AW(OTP_AW)) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_tag     (req_tag),
        .otp_rd_en   (otp_rd_en),
        .otp_rd_addr (otp_rd_addr),
        .otp_rd_data (otp_rd_data),
        .rsp_valid   (rsp_valid),
        .rsp_addr    (rsp_addr),
        .rsp_tag     (rsp_tag),
        .rsp_data    (rsp_data)
    );

    boot_ctrl #(.OTP_AW(OTP_AW), .KEY_WORDS(KEY_WORDS)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .sec_key      (sec_key),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_tag      (req_tag),
        .rsp_valid    (rsp_valid),
        .rsp_addr     (rsp_addr),
        .rsp_tag      (rsp_tag),
        .rsp_data     (rsp_data),
        .img_wr_en    (img_wr_en),
        .img_wr_addr  (img_wr_addr),
        .img_wr_data  (img_wr_data),
        .exec_strobe  (exec_strobe),
        .dl_enable    (dl_enable),
        .boot_fault   (boot_fault),
        .prog_allowed (prog_allowed)
    );

    boot_fuse_pulse #(.BIT_AW(BIT_AW), .CYCLES(BLOW_N)) u_pulse (
        .clk            (clk),
        .rst            (rst),
        .allowed        (prog_allowed),
        .prog_req       (prog_req),
        .prog_bit_addr  (prog_bit_addr),
        .fuse_blow      (fuse_blow),
        .fuse_blow_addr (fuse_blow_addr)
    );

    assign ram_wr_en   = img_wr_en;
    assign ram_wr_addr = RAM_AW'(img_wr_addr);
    assign ram_wr_data = img_wr_data;

endmodule

// File: rtl/boot_sequencer_chk.sv
module boot_sequencer_chk #(
    parameter int unsigned OTP_AW = 6,
    parameter int unsigned RAM_AW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ram_wr_en,
    input logic [RAM_AW-1:0] ram_wr_addr,
    input logic              fuse_blow,
    input logic [OTP_AW+4:0] fuse_blow_addr,
    input logic              dl_enable,
    input logic              exec_strobe,
    input logic              boot_fault
);

    assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        exec_strobe |=> !exec_strobe);

    assert_strobe_follows_copy_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(ram_wr_en) && !ram_wr_en) |-> exec_strobe);

    assert_no_write_at_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        exec_strobe |-> !ram_wr_en);

    assert_write_ascending_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(ram_wr_en) && ram_wr_en) |-> (ram_wr_addr == $past(ram_wr_addr) + RAM_AW'(1)));

    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        boot_fault |=> boot_fault);

    assert_fault_silent_R7: assert property (@(posedge clk) disable iff (rst)
        boot_fault |-> (!exec_strobe && !dl_enable && !ram_wr_en && !fuse_blow));

    assert_blank_no_exec_R2: assert property (@(posedge clk) disable iff (rst)
        dl_enable |-> (!ram_wr_en && !exec_strobe && !boot_fault));

    assert_blow_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (fuse_blow && $past(fuse_blow)) |-> $stable(fuse_blow_addr));

endmodule

bind boot_sequencer boot_sequencer_chk #(.OTP_AW(OTP_AW), .RAM_AW(RAM_AW)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ram_wr_en      (ram_wr_en),
    .ram_wr_addr    (ram_wr_addr),
    .fuse_blow      (fuse_blow),
    .fuse_blow_addr (fuse_blow_addr),
    .dl_enable      (dl_enable),
    .exec_strobe    (exec_strobe),
    .boot_fault     (boot_fault)
);

// File: tb/tb_boot_sequencer.sv
module tb_boot_sequencer;

    localparam int OTP_AW  = 5;
    localparam int DEPTH   = 32;
    localparam int KW      = 2;
    localparam int IMG_MAX = DEPTH - 2 - KW;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;
    localparam logic [31:0] MARK_OK = 32'hA5C3_0F01;
    localparam logic [31:0] K0 = 32'h1234_5678;
    localparam logic [31:0] K1 = 32'h0BAD_F00D;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst = 1'b1;
    logic              prog_req = 1'b0;
    logic [OTP_AW+4:0] prog_addr = '0;
    logic [63:0]       sec_key = {K1, K0};
    logic              otp_rd_en;
    logic [OTP_AW-1:0] otp_rd_addr;
    logic [31:0]       otp_rd_data = '0;
    logic              ram_wr_en;
    logic [OTP_AW-1:0] ram_wr_addr;
    logic [31:0]       ram_wr_data;
    logic              fuse_blow;
    logic [OTP_AW+4:0] fuse_blow_addr;
    logic              dl_enable, exec_strobe, boot_fault;

    // Variants that differ only in the blow pulse setting
    logic              lo_rd_en, hi_rd_en, lo_wr_en, hi_wr_en;
    logic [OTP_AW-1:0] lo_rd_addr, hi_rd_addr, lo_wr_addr, hi_wr_addr;
    logic [31:0]       lo_wr_data, hi_wr_data;
    logic              lo_blow, hi_blow, lo_dl, hi_dl, lo_ex, hi_ex, lo_ft, hi_ft;
    logic [OTP_AW+4:0] lo_baddr, hi_baddr;

    boot_sequencer #(.OTP_AW(OTP_AW), .RAM_AW(OTP_AW), .KEY_WORDS(KW), .CLK_MHZ(1), .BLOW_US(37)) dut (
        .clk(clk), .rst(rst), .otp_rd_en(otp_rd_en), .otp_rd_addr(otp_rd_addr), .otp_rd_data(otp_rd_data),
        .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data), .sec_key(sec_key),
        .prog_req(prog_req), .prog_bit_addr(prog_addr), .fuse_blow(fuse_blow), .fuse_blow_addr(fuse_blow_addr),
        .dl_enable(dl_enable), .exec_strobe(exec_strobe), .boot_fault(boot_fault));

    boot_sequencer #(.OTP_AW(OTP_AW), .RAM_AW(OTP_AW), .KEY_WORDS(KW), .CLK_MHZ(1), .BLOW_US(4)) dut_lo (
        .clk(clk), .rst(rst), .otp_rd_en(lo_rd_en), .otp_rd_addr(lo_rd_addr), .otp_rd_data(otp_rd_data),
        .ram_wr_en(lo_wr_en), .ram_wr_addr(lo_wr_addr), .ram_wr_data(lo_wr_data), .sec_key(sec_key),
        .prog_req(prog_req), .prog_bit_addr(prog_addr), .fuse_blow(lo_blow), .fuse_blow_addr(lo_baddr),
        .dl_enable(lo_dl), .exec_strobe(lo_ex), .boot_fault(lo_ft));

    boot_sequencer #(.OTP_AW(OTP_AW), .RAM_AW(OTP_AW), .KEY_WORDS(KW), .CLK_MHZ(1), .BLOW_US(250)) dut_hi (
        .clk(clk), .rst(rst), .otp_rd_en(hi_rd_en), .otp_rd_addr(hi_rd_addr), .otp_rd_data(otp_rd_data),
        .ram_wr_en(hi_wr_en), .ram_wr_addr(hi_wr_addr), .ram_wr_data(hi_wr_data), .sec_key(sec_key),
        .prog_req(prog_req), .prog_bit_addr(prog_addr), .fuse_blow(hi_blow), .fuse_blow_addr(hi_baddr),
        .dl_enable(hi_dl), .exec_strobe(hi_ex), .boot_fault(hi_ft));

    // OTP array model: one cycle read latency
    logic [31:0] otp [DEPTH];
    always @(posedge clk) if (otp_rd_en) otp_rd_data <= otp[otp_rd_addr];

    logic [31:0] ram [DEPTH];
    int vectors = 0, fails = 0, wd = 0;
    int cyc = 0, wr_count = 0, order_err = 0, strobe_count = 0, last_wr_cyc = 0, strobe_cyc = 0;
    int blow_n = 0, blow_lo = 0, blow_hi = 0, blow_addr_bad = 0;
    logic [OTP_AW+4:0] exp_blow_addr = '0;
    bit finished = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (ram_wr_en) begin
                if (int'(ram_wr_addr) != wr_count) order_err++;
                ram[ram_wr_addr] = ram_wr_data;
                wr_count++;
                last_wr_cyc = cyc;
            end
            if (exec_strobe) begin
                strobe_count++;
                strobe_cyc = cyc;
            end
            if (fuse_blow) begin
                blow_n++;
                if (fuse_blow_addr !== exp_blow_addr) blow_addr_bad++;
            end
            if (lo_blow) blow_lo++;
            if (hi_blow) blow_hi++;
        end
    end

    task automatic summary();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        wd++;
        if (wd > 100000 && !finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", wd);
            summary();
        end
    end

    task automatic check(string req, string what, longint act, longint exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] img_word(int seed, int i);
        return (32'(seed) * 32'h0100_0193) ^ ((32'(i) + 32'd1) * 32'h9E37_79B9);
    endfunction

    task automatic do_boot(logic [31:0] marker, logic [31:0] cfgw,
                           logic [31:0] k0, logic [31:0] k1, int seed, bit poke);
        for (int i = 0; i < DEPTH; i++) begin
            otp[i] = img_word(seed, i);
            ram[i] = SENT;
        end
        otp[IMG_MAX]     = k0;
        otp[IMG_MAX + 1] = k1;
        otp[DEPTH - 2]   = cfgw;
        otp[DEPTH - 1]   = marker;
        @(negedge clk);
        rst = 1'b1;
        prog_req = 1'b0;
        repeat (2) @(negedge clk);
        wr_count = 0; order_err = 0; strobe_count = 0; last_wr_cyc = 0; strobe_cyc = 0;
        blow_n = 0; blow_lo = 0; blow_hi = 0; blow_addr_bad = 0;
        // R1: everything quiet while reset is held
        check("R1", "outputs in reset",
              {exec_strobe, dl_enable, boot_fault, ram_wr_en, fuse_blow}, 5'b0);
        rst = 1'b0;
        if (poke) prog_req = 1'b1;
        @(negedge clk);
        // R1: first cycle after release
        check("R1", "outputs after release",
              {exec_strobe, dl_enable, boot_fault, ram_wr_en, fuse_blow}, 5'b0);
        repeat (2) @(negedge clk);
        prog_req = 1'b0;
        repeat (57) @(negedge clk);
    endtask

    task automatic expect_image(string req, int n, int seed);
        int bad;
        bad = 0;
        check(req, "write count", wr_count, n);
        for (int i = 0; i < DEPTH; i++) begin
            if (i < n) begin
                if (ram[i] !== img_word(seed, i)) bad++;
            end else if (ram[i] !== SENT) bad++;
        end
        check(req, "ram words wrong", bad, 0);
        check("R3", "write order errors", order_err, 0);
        check("R5", "strobe count", strobe_count, 1);
        if (n > 0) check("R5", "strobe lag after last write", strobe_cyc - last_wr_cyc, 1);
        check(req, "dl/fault", {dl_enable, boot_fault}, 2'b00);
    endtask

    task automatic try_prog(string req, logic [OTP_AW+4:0] a, int e_n, int e_lo, int e_hi);
        blow_n = 0; blow_lo = 0; blow_hi = 0; blow_addr_bad = 0;
        exp_blow_addr = a;
        prog_addr = a;
        prog_req = 1'b1;
        @(negedge clk);
        prog_req = 1'b0;
        repeat (5) @(negedge clk);
        // R10: second request while a pulse runs must not restart or extend it
        prog_addr = ~a;
        prog_req = 1'b1;
        @(negedge clk);
        prog_req = 1'b0;
        repeat (130) @(negedge clk);
        check(req, "blow cycles (37us)", blow_n, e_n);
        check("R9", "blow cycles (clamped low)", blow_lo, e_lo);
        check("R9", "blow cycles (clamped high)", blow_hi, e_hi);
        check("R8", "blow address mismatches", blow_addr_bad, 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) otp[i] = '0;

        // R2: blank marker, unlocked, request held through decision is ignored (R10)
        do_boot(32'h0, 32'h0, K0, K1, 1, 1'b1);
        check("R2", "dl_enable blank", dl_enable, 1);
        check("R2", "writes blank", wr_count, 0);
        check("R2", "strobes blank", strobe_count, 0);
        check("R2", "fault blank", boot_fault, 0);
        check("R10", "blow during decision", blow_n, 0);
        try_prog("R8", 10'h2A5, 37, 10, 100);

        // R2: fully blown marker also blank
        do_boot(32'hFFFF_FFFF, 32'h0000_0500, K0, K1, 2, 1'b0);
        check("R2", "dl_enable all-ones", dl_enable, 1);
        check("R2", "writes all-ones", wr_count, 0);
        check("R2", "strobes all-ones", strobe_count, 0);

        // R10: blank marker with lock bit set
        do_boot(32'h0, 32'h0000_0002, K0, K1, 3, 1'b0);
        check("R2", "dl_enable locked blank", dl_enable, 1);
        try_prog("R10", 10'h13C, 0, 0, 0);

        // R3/R4/R5: open boot over every length value; OTP key region deliberately wrong
        for (int n = 0; n < 32; n++) begin
            do_boot(MARK_OK, 32'(n) << 8, ~K0, ~K1, 10 + n, 1'b1);
            expect_image((n > IMG_MAX || n == 0) ? "R4" : "R3", (n > IMG_MAX) ? IMG_MAX : n, 10 + n);
            check("R10", "blow during copy", blow_n, 0);
        end

        // R8: programming after the execute strobe, unlocked
        do_boot(MARK_OK, 32'h0000_0500, ~K0, ~K1, 50, 1'b0);
        expect_image("R3", 5, 50);
        try_prog("R8", 10'h0F1, 37, 10, 100);

        // R10: programming after the strobe with lock set
        do_boot(MARK_OK, 32'h0000_0202, ~K0, ~K1, 51, 1'b0);
        expect_image("R3", 2, 51);
        try_prog("R10", 10'h301, 0, 0, 0);

        // R6: secure boot with matching key over every length value
        for (int n = 0; n < 32; n++) begin
            do_boot(MARK_OK, (32'(n) << 8) | 32'h1, K0, K1, 60 + n, 1'b0);
            expect_image("R6", (n > IMG_MAX) ? IMG_MAX : n, 60 + n);
        end

        // R7: mismatch on the first key word, then on the last only
        do_boot(MARK_OK, 32'h0000_0401, K0 ^ 32'h1, K1, 90, 1'b1);
        check("R7", "fault first word", boot_fault, 1);
        check("R7", "writes first word", wr_count, 0);
        check("R7", "strobes first word", strobe_count, 0);
        check("R7", "dl first word", dl_enable, 0);
        try_prog("R7", 10'h055, 0, 0, 0);
        check("R7", "fault held", boot_fault, 1);

        do_boot(MARK_OK, 32'h0000_1C01, K0, K1 ^ 32'h8000_0000, 91, 1'b0);
        check("R7", "fault last word", boot_fault, 1);
        check("R7", "writes last word", wr_count, 0);
        check("R7", "strobes last word", strobe_count, 0);
        check("R7", "dl last word", dl_enable, 0);

        summary();
    end

endmodule